// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns a packed burst-mode word and a column command into the column address of each beat of one SDRAM read or write burst. A mode load strobe captures the burst length, the beat ordering and the read latency from a 12-bit operand. A start strobe with a starting column and a read/write flag then launches a burst. The block steps the column through the burst in either linear-wrap or XOR order, and it can run a full-row burst that only a terminate request stops.

For reads, the block produces a data-valid strobe that follows the selected latency. It also produces an output-enable that a per-cycle mask bit can drop two cycles later. For writes, it produces a write-enable and the beat's column one cycle after each beat, with the mask bit of that same beat clearing the enable. The memory array, refresh and bank timing sit outside this block. A terminate input stands in for both an explicit stop and a precharge to the bank.

Top module: `sdram_burst_seq`

## Requirements
- R1: Mode operand bits [2:0] select the burst length: 000 is 1 beat, 001 is 2, 010 is 4, 011 is 8 and 111 is a full row. The busy flag stays high for exactly that many cycles after the start cycle.
- R2: Mode operand bit 3 selects the ordering: 0 is linear and 1 is XOR. A full-row length together with XOR ordering is rejected as a bad load.
- R3: Mode operand bits [6:4] select the read latency: 010 is 2 cycles and 011 is 3 cycles. Every other latency code is rejected.
- R4: A load is rejected when it has a reserved length code, a reserved latency code, full row with XOR ordering, or any operand bit from 7 up to the top bit set. A rejected load sets mode_err one cycle after the load and leaves the previous settings in force. An accepted load clears mode_err.
- R5: After reset, busy, rd_valid, dq_oe, wr_en, col and mode_err are all 0. The settings are 1 beat, linear ordering and latency 2.
- R6: With linear ordering and length L, beat k (shown on col in the k-th cycle after the start cycle) is the starting column with its low log2(L) bits replaced by (start + k) mod L.
- R7: With XOR ordering and length L, beat k is the starting column XOR k.
- R8: A full-row burst steps the column by one per cycle, wraps from the top column to 0, and keeps running until a terminate request.
- R9: col holds its value whenever no burst is stepping.
- R10: A terminate request without a start in the same cycle clears busy in the next cycle, and col keeps the last beat.
- R11: For a read that starts in cycle t with latency CL, rd_valid is high in cycles t+CL through t+CL+L-1, one cycle per beat that was issued.
- R12: dq_oe equals rd_valid, except that a mask bit high in cycle m forces dq_oe low in cycle m+2.
- R13: For a write, wr_en is high in the cycle after each beat, and wr_col then carries that beat's column. A mask bit high in the beat's own cycle clears only that beat's wr_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_ld | input | 1 | Load strobe for the burst-mode word |
| mode_op | input | OP_W (12) | Packed burst-mode word |
| start | input | 1 | Starts a burst in this cycle |
| start_col | input | COL_W (10) | First column of the burst |
| start_rd | input | 1 | 1 for read burst, 0 for write burst |
| stop | input | 1 | Terminate request (stop or precharge) |
| rd_mask | input | 1 | Per-cycle data mask |
| col | output | COL_W (10) | Current beat column |
| busy | output | 1 | Burst in progress |
| rd_valid | output | 1 | Read data valid, latency-aligned |
| dq_oe | output | 1 | Read output enable after masking |
| wr_en | output | 1 | Write beat enable, one cycle after the beat |
| wr_col | output | COL_W (10) | Column of the write beat flagged by wr_en |
| mode_err | output | 1 | Last mode load was rejected |

## Verification
The sweep runs every length of 1, 2, 4 and 8 under both orderings and both latencies, with seventeen starting columns and both burst directions. The starting columns include every offset inside an aligned block, so an error in the wrap boundary or in the XOR formula shows up as a wrong column on a specific beat. Each burst uses a different mask pattern, which shows whether the read mask acts two cycles late and the write mask acts in the same cycle. Separate runs cover a full-row burst that crosses the top column and is then terminated, and a terminate in the middle of an 8-beat read, where the valid tail must still cover only the issued beats. They also cover a set of rejected mode words, each followed by a burst that shows the earlier settings are still in force.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  typedef struct packed {
    logic [1:0] len_log;
    logic       full_row;
    order_e     order;
    logic       lat3;
  } burst_cfg_t;

  localparam burst_cfg_t CFG_RESET = '{
    len_log:  2'd0,
    full_row: 1'b0,
    order:    ORD_LINEAR,
    lat3:     1'b0
  };

  localparam logic [2:0] LEN_FULL_CODE = 3'b111;
  localparam logic [2:0] LAT2_CODE     = 3'b010;
  localparam logic [2:0] LAT3_CODE     = 3'b011;

endpackage

// File: rtl/bseq_mode.sv
module bseq_mode
  import bseq_pkg::*;
#(
  parameter int OP_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld,
  input  logic [OP_W-1:0] op,
  output burst_cfg_t      cfg,
  output logic            err
);

  localparam int HI_W = OP_W - 7;

  burst_cfg_t dec;
  logic       bad;

  always_comb begin
    dec = cfg;
    bad = 1'b0;
    dec.order = order_e'(op[3]);
    unique case (op[2:0])
      3'b000, 3'b001, 3'b010, 3'b011: begin
        dec.len_log  = op[1:0];
        dec.full_row = 1'b0;
      end
      LEN_FULL_CODE: begin
        dec.len_log  = 2'd0;
        dec.full_row = 1'b1;
      end
      default: bad = 1'b1;
    endcase
    if (dec.full_row && (dec.order == ORD_XOR)) bad = 1'b1;
    unique case (op[6:4])
      LAT2_CODE: dec.lat3 = 1'b0;
      LAT3_CODE: dec.lat3 = 1'b1;
      default:   bad = 1'b1;
    endcase
    if (op[OP_W-1:7] != {HI_W{1'b0}}) bad = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
      err <= 1'b0;
    end else if (ld) begin
      if (bad) begin
        err <= 1'b1;
      end else begin
        cfg <= dec;
        err <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bseq_addr.sv
module bseq_addr
  import bseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       len_log,
  input  logic             full_row,
  input  order_e           order,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_rd,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             busy,
  output logic             is_rd
);

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [1:0]       len_q;
  logic             full_q;
  order_e           ord_q;

  logic [COL_W-1:0] lmask;
  logic [COL_W-1:0] beat_nxt;
  logic [COL_W-1:0] col_step;
  logic             last;

  always_comb begin
    lmask    = full_q ? {COL_W{1'b1}} : ~({COL_W{1'b1}} << len_q);
    beat_nxt = beat_q + 1'b1;
    last     = !full_q && (beat_q == lmask);
    if (ord_q == ORD_XOR)
      col_step = base_q ^ (beat_nxt & lmask);
    else
      col_step = (base_q & ~lmask) | ((base_q + beat_nxt) & lmask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
      len_q  <= '0;
      full_q <= 1'b0;
      ord_q  <= ORD_LINEAR;
      col    <= '0;
      busy   <= 1'b0;
      is_rd  <= 1'b0;
    end else if (start) begin
      base_q <= start_col;
      beat_q <= '0;
      len_q  <= len_log;
      full_q <= full_row;
      ord_q  <= order;
      col    <= start_col;
      busy   <= 1'b1;
      is_rd  <= start_rd;
    end else if (busy) begin
      if (stop || last) begin
        busy <= 1'b0;
      end else begin
        beat_q <= beat_nxt;
        col    <= col_step;
      end
    end
  end

endmodule

// File: rtl/bseq_pipe.sv
module bseq_pipe #(
  parameter int COL_W    = 10,
  parameter int CL_MAX   = 3,
  parameter int MASK_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lat3,
  input  logic             busy,
  input  logic             is_rd,
  input  logic [COL_W-1:0] col,
  input  logic             rd_mask,
  output logic             rd_valid,
  output logic             dq_oe,
  output logic             wr_en,
  output logic [COL_W-1:0] wr_col
);

  localparam int TAPS  = CL_MAX - 1;
  localparam int SEL_W = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int MD    = MASK_LAT - 1;

  logic [TAPS-2:0] dly;
  logic [TAPS-1:0] tap;
  logic [MD-1:0]   mdly;
  logic [SEL_W-1:0] sel;
  logic            rd_beat;

  assign rd_beat = busy & is_rd;
  assign tap     = {dly, rd_beat};
  assign sel     = lat3 ? SEL_W'(1) : SEL_W'(0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dly  <= '0;
      mdly <= '0;
    end else begin
      for (int i = TAPS - 2; i > 0; i--) dly[i] <= dly[i-1];
      dly[0] <= rd_beat;
      for (int i = MD - 1; i > 0; i--) mdly[i] <= mdly[i-1];
      mdly[0] <= rd_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      dq_oe    <= 1'b0;
      wr_en    <= 1'b0;
      wr_col   <= '0;
    end else begin
      rd_valid <= tap[sel];
      dq_oe    <= tap[sel] & ~mdly[MD-1];
      wr_en    <= busy & ~is_rd & ~rd_mask;
      wr_col   <= col;
    end
  end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import bseq_pkg::*;
#(
  parameter int COL_W    = 10,
  parameter int OP_W     = 12,
  parameter int CL_MAX   = 3,
  parameter int MASK_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_ld,
  input  logic [OP_W-1:0]  mode_op,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_rd,
  input  logic             stop,
  input  logic             rd_mask,
  output logic [COL_W-1:0] col,
  output logic             busy,
  output logic             rd_valid,
  output logic             dq_oe,
  output logic             wr_en,
  output logic [COL_W-1:0] wr_col,
  output logic             mode_err
);

  burst_cfg_t cfg;
  logic       is_rd;

  bseq_mode #(.OP_W(OP_W)) i_mode (
    .clk (clk),
    .rst (rst),
    .ld  (mode_ld),
    .op  (mode_op),
    .cfg (cfg),
    .err (mode_err)
  );

  bseq_addr #(.COL_W(COL_W)) i_addr (
    .clk       (clk),
    .rst       (rst),
    .len_log   (cfg.len_log),
    .full_row  (cfg.full_row),
    .order     (cfg.order),
    .start     (start),
    .start_col (start_col),
    .start_rd  (start_rd),
    .stop      (stop),
    .col       (col),
    .busy      (busy),
    .is_rd     (is_rd)
  );

  bseq_pipe #(
    .COL_W    (COL_W),
    .CL_MAX   (CL_MAX),
    .MASK_LAT (MASK_LAT)
  ) i_pipe (
    .clk      (clk),
    .rst      (rst),
    .lat3     (cfg.lat3),
    .busy     (busy),
    .is_rd    (is_rd),
    .col      (col),
    .rd_mask  (rd_mask),
    .rd_valid (rd_valid),
    .dq_oe    (dq_oe),
    .wr_en    (wr_en),
    .wr_col   (wr_col)
  );

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             stop,
  input logic             rd_mask,
  input logic [COL_W-1:0] col,
  input logic             busy,
  input logic             rd_valid,
  input logic             dq_oe,
  input logic             wr_en
);

  assert_reset_quiet_R5: assert property (@(posedge clk)
    rst |=> (!busy && !rd_valid && !dq_oe && !wr_en));

  assert_stop_ends_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && stop && !start) |=> !busy);

  assert_col_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(col));

  assert_oe_within_valid_R12: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> rd_valid);

  assert_rd_mask_late_R12: assert property (@(posedge clk) disable iff (rst)
    rd_mask |-> ##2 !dq_oe);

  assert_wr_mask_same_R13: assert property (@(posedge clk) disable iff (rst)
    rd_mask |=> !wr_en);

  assert_wr_follows_beat_R13: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(busy));

endmodule

bind sdram_burst_seq bseq_chk #(.COL_W(COL_W)) i_bseq_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .stop     (stop),
  .rd_mask  (rd_mask),
  .col      (col),
  .busy     (busy),
  .rd_valid (rd_valid),
  .dq_oe    (dq_oe),
  .wr_en    (wr_en)
);

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;

  localparam int COL_W = 10;
  localparam int OP_W  = 12;
  localparam int ROW   = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mode_ld = 1'b0;
  logic [OP_W-1:0]  mode_op = '0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             start_rd = 1'b0;
  logic             stop = 1'b0;
  logic             rd_mask = 1'b0;
  logic [COL_W-1:0] col;
  logic             busy;
  logic             rd_valid;
  logic             dq_oe;
  logic             wr_en;
  logic [COL_W-1:0] wr_col;
  logic             mode_err;

  int checks = 0;
  int errors = 0;
  int m_len = 0;
  int m_ty  = 0;
  int m_cl  = 2;

  sdram_burst_seq i_sdram_burst_seq (
    .clk (clk), .rst (rst), .mode_ld (mode_ld), .mode_op (mode_op),
    .start (start), .start_col (start_col), .start_rd (start_rd),
    .stop (stop), .rd_mask (rd_mask), .col (col), .busy (busy),
    .rd_valid (rd_valid), .dq_oe (dq_oe), .wr_en (wr_en),
    .wr_col (wr_col), .mode_err (mode_err)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [OP_W-1:0] mkop(int blc, int ty, int clc, int hi);
    logic [OP_W-1:0] op;
    op      = '0;
    op[2:0] = blc[2:0];
    op[3]   = ty[0];
    op[6:4] = clc[2:0];
    op[8]   = hi[0];
    return op;
  endfunction

  function automatic int ecol(int s, int k);
    int ln, base, off;
    ln   = 1 << m_len;
    base = s - (s % ln);
    off  = s % ln;
    if (m_ty == 0) return base + ((off + k) % ln);
    return base + (off ^ k);
  endfunction

  task automatic load(input logic [OP_W-1:0] op, input int exp_err, input string tag);
    @(negedge clk);
    mode_ld = 1'b1;
    mode_op = op;
    @(negedge clk);
    mode_ld = 1'b0;
    check(tag, int'(mode_err), exp_err);
  endtask

  task automatic run_burst(input int rd, input int s, input logic [15:0] pat);
    int ln;
    int erv, eoe, ewr;
    ln = 1 << m_len;
    @(negedge clk);
    start     = 1'b1;
    start_col = COL_W'(s);
    start_rd  = rd[0];
    rd_mask   = pat[0];
    for (int j = 0; j <= ln + m_cl + 2; j++) begin
      @(negedge clk);
      start = 1'b0;
      check("R1 R9 busy length", int'(busy), (j < ln) ? 1 : 0);
      if (j < ln) begin
        if (m_ty == 0) check("R6 R1 linear column", int'(col), ecol(s, j));
        else           check("R7 R2 xor column", int'(col), ecol(s, j));
      end else begin
        check("R9 column hold", int'(col), ecol(s, ln - 1));
      end
      erv = (rd != 0 && j >= m_cl - 1 && j <= m_cl + ln - 2) ? 1 : 0;
      check("R11 R3 read valid", int'(rd_valid), erv);
      eoe = (erv != 0 && j >= 1 && !pat[(j - 1) & 15]) ? 1 : 0;
      check("R12 output enable", int'(dq_oe), eoe);
      ewr = (rd == 0 && j >= 1 && j <= ln && !pat[j & 15]) ? 1 : 0;
      check("R13 write enable", int'(wr_en), ewr);
      if (ewr != 0) check("R13 write column", int'(wr_col), ecol(s, j - 1));
      rd_mask = pat[(j + 1) & 15];
    end
    rd_mask = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R5 reset busy", int'(busy), 0);
    check("R5 reset col", int'(col), 0);
    check("R5 reset rd_valid", int'(rd_valid), 0);
    check("R5 reset dq_oe", int'(dq_oe), 0);
    check("R5 reset wr_en", int'(wr_en), 0);
    check("R5 reset mode_err", int'(mode_err), 0);
    run_burst(1, 13, 16'h0000);
    run_burst(0, 7, 16'h0000);

    // full sweep of length, ordering, latency, start column and direction
    for (int cl = 2; cl <= 3; cl++)
      for (int bl = 0; bl <= 3; bl++)
        for (int ty = 0; ty <= 1; ty++) begin
          load(mkop(bl, ty, cl, 0), 0, "R4 R1 R2 R3 accepted load");
          m_len = bl; m_ty = ty; m_cl = cl;
          for (int s = 0; s <= 16; s++)
            for (int rd = 0; rd <= 1; rd++) begin
              logic [15:0] pat;
              int sc;
              sc  = (s == 16) ? 1001 : s;
              pat = 16'hA5C3 ^ 16'(s * 16'h1357) ^ 16'(rd * 16'h0F0F) ^ 16'(bl * 16'h2222);
              run_burst(rd, sc, pat);
            end
        end

    // terminate in the middle of an 8-beat read, latency 3
    load(mkop(3, 0, 3, 0), 0, "R4 accepted load");
    m_len = 3; m_ty = 0; m_cl = 3;
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(5); start_rd = 1'b1;
    for (int j = 0; j <= 6; j++) begin
      @(negedge clk);
      start = 1'b0;
      stop  = (j == 2) ? 1'b1 : 1'b0;
      if (j == 3) begin
        check("R10 busy cleared", int'(busy), 0);
        check("R10 column kept", int'(col), ecol(5, 2));
      end
      if (j == 4) check("R11 valid tail after stop", int'(rd_valid), 1);
      if (j == 5) check("R11 no valid beyond issued beats", int'(rd_valid), 0);
    end
    stop = 1'b0;

    // full-row burst across the top column, then terminated
    load(mkop(7, 0, 2, 0), 0, "R4 R8 accepted full row");
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(ROW - 4); start_rd = 1'b1;
    for (int j = 0; j <= 13; j++) begin
      @(negedge clk);
      start = 1'b0;
      stop  = (j == 11) ? 1'b1 : 1'b0;
      if (j <= 11) begin
        check("R8 full row busy", int'(busy), 1);
        check("R8 full row column", int'(col), (ROW - 4 + j) % ROW);
      end
      if (j == 12) begin
        check("R8 R10 full row stopped", int'(busy), 0);
        check("R11 full row last valid", int'(rd_valid), 1);
      end
      if (j == 13) check("R11 full row valid ends", int'(rd_valid), 0);
    end
    stop = 1'b0;

    // rejected loads keep the earlier settings
    load(mkop(2, 0, 3, 0), 0, "R4 accepted load");
    m_len = 2; m_ty = 0; m_cl = 3;
    load(mkop(4, 0, 3, 0), 1, "R4 reserved length");
    load(mkop(7, 1, 2, 0), 1, "R2 R4 full row with xor");
    load(mkop(1, 0, 1, 0), 1, "R3 R4 reserved latency");
    load(mkop(1, 0, 2, 1), 1, "R4 upper bit set");
    run_burst(1, 6, 16'h0000);
    run_burst(0, 9, 16'h0024);
    load(mkop(1, 1, 2, 0), 0, "R4 error cleared");
    m_len = 1; m_ty = 1; m_cl = 2;
    run_burst(1, 3, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule